// File: doc/BRIEF.md
# Strobe-Multiplexed Key Matrix Scanner

This block walks a key matrix by raising one of twelve strobe lines at a time and reading four sense inputs while that strobe is up. Each advance of the strobe is paced by a single-cycle scan-step tick from a slower timebase. The cycle that carries the tick is the last cycle of the current strobe step. In that cycle the synchronised sense bits are written into the slot of a key-state register that belongs to the active strobe, and the strobe moves on to the next line.

The sense inputs come from the outside world, so they pass through a two-flop synchroniser before anything samples them. The 48-bit key-state register is a plain level output that a host may read at any time; it changes only on a tick. After the sample for the last strobe has been written, a scan-complete pulse tells the host that a full pass of the matrix is now in the register. The outputs are plain levels and pulses with no valid/ready handshake. Nothing at this edge can push back, and a host that misses a pulse loses nothing, because the register keeps the latest pass until the next tick overwrites it slot by slot.

Top module: `keymx_scanner`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the strobe output is 12'h001, the key-state output is all zeros and the scan-complete output is 0.
- R2: Exactly one strobe bit is high in every cycle.
- R3: On a clock edge where the tick is high, the active strobe moves from bit n to bit n+1. On an edge without a tick the strobe does not change.
- R4: A tick while strobe bit 11 is active returns the strobe to bit 0, so the order is bit 0, then bit 1, up to bit 11, then bit 0 again.
- R5: On a tick edge, the synchronised sense bits are stored at key-state bits 4*n+3 down to 4*n, where n is the index of the strobe bit active before that edge. Sense bit 0 goes into the lowest of these positions.
- R6: A tick changes only the slot of the active strobe. Without a tick the key-state output does not change, whatever the sense inputs do.
- R7: Scan-complete is high for exactly the one cycle after a tick edge that stored the slot of strobe bit 11. It is low at all other times.
- R8: A sense value reaches storage only if it was present at the two clock edges before the tick edge. A value applied for only one edge before the tick edge, or applied together with the tick, is not stored; the earlier settled value is stored instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_tick | input | 1 | One-cycle pulse that ends the current strobe step |
| sense_in | input | 4 | Raw key sense inputs, bit 0 first |
| strobe_o | output | 12 | One-hot strobe lines, bit 0 first |
| key_state_o | output | 48 | Latched key states, four bits per strobe |
| scan_done_o | output | 1 | One-cycle pulse after the last strobe slot is stored |

## Verification
If the strobe sequencer lost its one-hot state or skipped a line, this would show on the strobe pins at the next edge. One tick later it would also show as a sense sample written into the wrong four-bit slot. If the synchroniser were shortened or lengthened, a sense change applied close to the tick would be stored one step early or late, and the bench aims at exactly that edge. If scan-complete were raised at the wrong step, the fault would appear within one tick, because the bench checks the pulse after every store over two full passes.

// File: rtl/keymx_pkg.sv
package keymx_pkg;

  // Lowest key-state bit of the slot that belongs to a strobe index.
  function automatic int unsigned slot_base(input int unsigned strobe_idx,
                                            input int unsigned slot_w);
    return strobe_idx * slot_w;
  endfunction

endpackage

// File: rtl/keymx_sync.sv
module keymx_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/keymx_strobe_seq.sv
module keymx_strobe_seq #(
  parameter int unsigned N_STROBE = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  output logic [N_STROBE-1:0] strobe_o,
  output logic                done_o
);

  logic [N_STROBE-1:0] ring_q;
  logic                done_q;
  logic                at_last;

  assign at_last = ring_q[N_STROBE-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_q <= N_STROBE'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= tick_i && at_last;
      if (tick_i) ring_q <= {ring_q[N_STROBE-2:0], ring_q[N_STROBE-1]};
    end
  end

  assign strobe_o = ring_q;
  assign done_o   = done_q;

endmodule

// File: rtl/keymx_key_store.sv
module keymx_key_store
  import keymx_pkg::*;
#(
  parameter int unsigned ROWS = 12,
  parameter int unsigned COLS = 4,
  localparam int unsigned BITS = ROWS * COLS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_i,
  input  logic [ROWS-1:0] row_sel_i,
  input  logic [COLS-1:0] sense_i,
  output logic [BITS-1:0] keys_o
);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int unsigned LO = slot_base(r, COLS);
    logic [COLS-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                     slot_q <= '0;
      else if (tick_i && row_sel_i[r]) slot_q <= sense_i;
    end
    assign keys_o[LO +: COLS] = slot_q;
  end

endmodule

// File: rtl/keymx_scanner.sv
module keymx_scanner #(
  parameter int unsigned N_STROBE    = 12,
  parameter int unsigned N_SENSE     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned KEY_BITS   = N_STROBE * N_SENSE
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step_tick,
  input  logic [N_SENSE-1:0]  sense_in,
  output logic [N_STROBE-1:0] strobe_o,
  output logic [KEY_BITS-1:0] key_state_o,
  output logic                scan_done_o
);

  logic [N_SENSE-1:0]  sense_sync;
  logic [N_STROBE-1:0] strobe_w;

  keymx_sync #(.WIDTH(N_SENSE), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (sense_in),
    .sync_o  (sense_sync)
  );

  keymx_strobe_seq #(.N_STROBE(N_STROBE)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (step_tick),
    .strobe_o (strobe_w),
    .done_o   (scan_done_o)
  );

  keymx_key_store #(.ROWS(N_STROBE), .COLS(N_SENSE)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (step_tick),
    .row_sel_i (strobe_w),
    .sense_i   (sense_sync),
    .keys_o    (key_state_o)
  );

  assign strobe_o = strobe_w;

endmodule

// File: rtl/keymx_scanner_chk.sv
module keymx_scanner_chk #(
  parameter int unsigned N_STROBE = 12,
  parameter int unsigned KEY_BITS = 48
) (
  input logic                clk,
  input logic                rst_n,
  input logic                step_tick,
  input logic [N_STROBE-1:0] strobe_o,
  input logic [KEY_BITS-1:0] key_state_o,
  input logic                scan_done_o
);

  logic live_q;
  always_ff @(posedge clk) live_q <= rst_n;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> $countones(strobe_o) == 1); // R2

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && step_tick && !strobe_o[N_STROBE-1] |=>
      strobe_o == ($past(strobe_o) << 1)); // R3

  AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !step_tick |=> $stable(strobe_o)); // R3

  AST_WRAP_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && step_tick && strobe_o[N_STROBE-1] |=>
      strobe_o == N_STROBE'(1)); // R4

  AST_KEYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !step_tick |=> $stable(key_state_o)); // R6

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && step_tick && strobe_o[N_STROBE-1] |=> scan_done_o); // R7

  AST_DONE_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    live_q && !(step_tick && strobe_o[N_STROBE-1]) |=> !scan_done_o); // R7

endmodule

bind keymx_scanner keymx_scanner_chk #(
  .N_STROBE (N_STROBE),
  .KEY_BITS (KEY_BITS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .step_tick   (step_tick),
  .strobe_o    (strobe_o),
  .key_state_o (key_state_o),
  .scan_done_o (scan_done_o)
);

// File: tb/keymx_scanner_tb.sv
module keymx_scanner_tb;

  localparam int NS = 12;
  localparam int NK = 4;
  localparam int NB = NS * NK;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          step_tick = 1'b0;
  logic [NK-1:0] sense_in = '0;
  logic [NS-1:0] strobe_o;
  logic [NB-1:0] key_state_o;
  logic          scan_done_o;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  logic [NB-1:0] exp_keys;
  int            exp_idx;

  localparam logic [3:0] PATS [24] = '{
    4'h1, 4'h2, 4'h4, 4'h8, 4'hF, 4'h0, 4'hA, 4'h5, 4'h3, 4'hC, 4'h9, 4'h6,
    4'h7, 4'hE, 4'hB, 4'hD, 4'h0, 4'hF, 4'h1, 4'h8, 4'h5, 4'hA, 4'h2, 4'h4
  };

  always #5 clk = ~clk;

  keymx_scanner u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .step_tick   (step_tick),
    .sense_in    (sense_in),
    .strobe_o    (strobe_o),
    .key_state_o (key_state_o),
    .scan_done_o (scan_done_o)
  );

  task automatic check(input string req, input string what,
                       input logic [NB-1:0] got, input logic [NB-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Present a sense value, let it settle through the synchroniser, then tick.
  // Returns at the negedge just after the storing edge.
  task automatic step_with(input logic [3:0] val, input int settle);
    sense_in = val;
    repeat (settle) @(negedge clk);
    step_tick = 1'b1;
    @(negedge clk);
    step_tick = 1'b0;
  endtask

  task automatic check_after_store(input string req, input logic [3:0] stored);
    logic was_last;
    was_last = (exp_idx == NS - 1);
    exp_keys[exp_idx*NK +: NK] = stored;
    exp_idx = was_last ? 0 : exp_idx + 1;
    check(req, "strobe", NB'(strobe_o), NB'(1) << exp_idx);
    check(req, "keys", key_state_o, exp_keys);
    check("R7", "done after store", NB'(scan_done_o), NB'(was_last));
  endtask

  initial begin
    exp_keys = '0;
    exp_idx  = 0;
    repeat (3) @(negedge clk);
    check("R1", "strobe in reset", NB'(strobe_o), NB'(1));
    check("R1", "keys in reset", key_state_o, '0);
    check("R1", "done in reset", NB'(scan_done_o), '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "strobe after release", NB'(strobe_o), NB'(1));
    check("R1", "keys after release", key_state_o, '0);

    // R5 R3 R4 R7: two full passes driven from the table
    for (int i = 0; i < 24; i++) begin
      step_with(PATS[i], 3);
      check_after_store("R5", PATS[i]);
      check("R2", "one strobe", NB'($countones(strobe_o)), NB'(1));
      @(negedge clk);
      check("R7", "done one cycle", NB'(scan_done_o), '0);
    end

    // R6: sense toggling with no tick leaves everything unchanged
    for (int j = 0; j < 8; j++) begin
      sense_in = 4'(j * 3 + 1);
      @(negedge clk);
    end
    check("R6", "keys idle", key_state_o, exp_keys);
    check("R3", "strobe idle", NB'(strobe_o), NB'(1) << exp_idx);
    check("R7", "done idle", NB'(scan_done_o), '0);

    // R8: settle 4'h6, then change together with the tick
    step_with(4'h6, 3);
    check_after_store("R8", 4'h6);
    step_with(4'h9, 0);
    check_after_store("R8", 4'h6);
    // change one edge before the tick: still the old value
    step_with(4'h3, 1);
    check_after_store("R8", 4'h9);
    // two edges before the tick: new value stored
    step_with(4'hC, 2);
    check_after_store("R8", 4'hC);

    // R4: run to the last strobe and wrap
    while (exp_idx != NS - 1) begin
      step_with(4'h0, 3);
      check_after_store("R4", 4'h0);
    end
    step_with(4'hF, 3);
    check_after_store("R4", 4'hF);
    check("R4", "wrap to first", NB'(strobe_o), NB'(1));

    // R1: reset in mid-scan clears the state
    step_with(4'h5, 3);
    check_after_store("R5", 4'h5);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "keys after mid reset", key_state_o, '0);
    check("R1", "strobe after mid reset", NB'(strobe_o), NB'(1));
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "done after mid reset", NB'(scan_done_o), '0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule